// File: doc/BRIEF.md
# Non-Volatile Byte Memory Programming Controller

This block lets a processor program and read a 128-byte on-chip non-volatile store through three registers on a simple register bus. The registers are an address register, a data register and a control register. The store is modelled as a flop array. Each programming operation is one of three kinds: erase followed by write, erase alone, or write alone. Each kind keeps the controller busy for its own number of clock cycles, and the byte is committed on the last busy cycle.

A program request only takes effect after a separate arming step, and only within a short window after it. This means a single stray register write cannot start an operation. The operation kind is locked while busy. A reset that arrives mid-operation lets the operation finish and keeps the kind. A level-type ready interrupt tells software that the store can accept new work.

The register bus is plain and has no back-pressure. A write is taken on the clock edge where `bus_wr` is high. A read returns the selected register combinationally. There is no data stream at the edge of the block, so it has no valid/ready pair.

Top module: `eectl_top`

## Requirements
- R1: After reset the address register and the data register read 0x00. The control register reads 0x00 when no operation is running. `irq` is low.
- R2: The register is chosen by `bus_sel`: 0 selects address, 1 selects data, 2 selects control, and 3 reads 0 and ignores writes. Control layout: bit 0 read, bit 1 program/busy, bit 2 arm, bit 3 interrupt enable, bits 5:4 kind, bits 7:6 reserved. The reserved bits always read 0, whatever was written to them.
- R3: Kind 00 sets the addressed byte to the data register value. The program bit stays set for exactly ATOMIC_CYC cycles and then clears by itself.
- R4: Kind 01 sets the addressed byte to 0xFF and stays busy for exactly SPLIT_CYC cycles.
- R5: Kind 10 sets the addressed byte to its old value ANDed with the data register, and stays busy for exactly SPLIT_CYC cycles.
- R6: A program request with kind 11 starts nothing.
- R7: A program request starts an operation only if arm was written to 1 within the previous ARM_WIN cycles. The request may arrive on the ARM_WIN-th cycle after the arm write, but not one cycle later. Without arming, a request starts nothing.
- R8: While busy, writes to the kind bits leave them unchanged, and a new program request neither starts nor prolongs an operation.
- R9: Writing 1 to the read bit while idle loads the data register with the addressed byte by the next cycle. The read bit always reads 0. While busy, a read request leaves the data register unchanged.
- R10: `irq` is high exactly when the interrupt enable bit is set, `gie` is high and no operation is running.
- R11: A reset while busy keeps the kind bits, and the operation runs to completion. A reset while idle clears the kind bits to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| gie | input | 1 | Global interrupt enable from the processor |
| irq | output | 1 | Ready interrupt, level type |

## Verification
The embedded properties assume that reset is held for longer than the longest operation counter can run after power-up, so that the busy state is settled before any check is live. The bench holds reset for 100 cycles, which is well above the reduced durations it uses. The properties also assume that every register write lasts exactly one cycle. The bench's write task always drops `bus_wr` after a single edge and changes the bus only on falling edges.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  typedef enum logic [1:0] {
    EM_ATOMIC = 2'b00,
    EM_ERASE  = 2'b01,
    EM_WRITE  = 2'b10,
    EM_RSVD   = 2'b11
  } ee_mode_e;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } ee_sel_e;

  localparam int B_RD  = 0;
  localparam int B_GO  = 1;
  localparam int B_ARM = 2;
  localparam int B_RIE = 3;
  localparam int B_M0  = 4;
  localparam int B_M1  = 5;
endpackage

// File: rtl/eectl_arm.sv
module eectl_arm #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic armed
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            left_q <= '0;
    else if (load)         left_q <= CW'(WIN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign armed = (left_q != '0);

  // R7
  arm_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> armed);
endmodule

// File: rtl/eectl_seq.sv
module eectl_seq
  import eectl_pkg::*;
#(
  parameter int AW         = 7,
  parameter int DW         = 8,
  parameter int ATOMIC_CYC = 68000,
  parameter int SPLIT_CYC  = 36000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  ee_mode_e      mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          done,
  output ee_mode_e      op_mode,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  localparam int MAXC = (ATOMIC_CYC > SPLIT_CYC) ? ATOMIC_CYC : SPLIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          accept;
  logic [CW-1:0] dur;

  assign accept = rst_n && start && !busy_q && (mode != EM_RSVD);
  assign dur    = (mode == EM_ATOMIC) ? CW'(ATOMIC_CYC) : CW'(SPLIT_CYC);

  // a running operation ignores reset and always completes
  always_ff @(posedge clk) begin
    if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end else if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cnt_q   <= dur;
      op_mode <= mode;
      op_addr <= addr;
      op_data <= data;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == CW'(1));

  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (!busy_q) run_len <= '0;
    else         run_len <= run_len + 1'b1;
  end

  // R3 R4 R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_len == ((op_mode == EM_ATOMIC) ? (CW+1)'(ATOMIC_CYC)
                                                          : (CW+1)'(SPLIT_CYC))));
endmodule

// File: rtl/eectl_mem.sv
module eectl_mem
  import eectl_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  ee_mode_e      wmode,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      case (wmode)
        EM_ATOMIC: cells[waddr] <= wdata;
        EM_ERASE:  cells[waddr] <= '1;
        EM_WRITE:  cells[waddr] <= cells[waddr] & wdata;
        default:   ;
      endcase
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eectl_top.sv
module eectl_top
  import eectl_pkg::*;
#(
  parameter int AW         = 7,
  parameter int ATOMIC_CYC = 68000,
  parameter int SPLIT_CYC  = 36000,
  parameter int ARM_WIN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       gie,
  output logic       irq
);
  localparam int DW = 8;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rie_q;
  ee_mode_e      mode_q;
  logic          wr_addr, wr_data, wr_ctrl;
  logic          rd_fire, go_req, arm_load, armed, busy, done;
  ee_mode_e      op_mode, req_mode;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, mem_rdata;

  assign wr_addr  = bus_wr && (bus_sel == SEL_ADDR);
  assign wr_data  = bus_wr && (bus_sel == SEL_DATA);
  assign wr_ctrl  = bus_wr && (bus_sel == SEL_CTRL);
  assign req_mode = ee_mode_e'(bus_wdata[B_M1:B_M0]);
  assign rd_fire  = wr_ctrl && bus_wdata[B_RD] && !busy;
  assign go_req   = wr_ctrl && bus_wdata[B_GO] && armed;
  assign arm_load = wr_ctrl && bus_wdata[B_ARM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rie_q  <= 1'b0;
      if (!busy) mode_q <= EM_ATOMIC;
    end else begin
      if (wr_addr) addr_q <= bus_wdata[AW-1:0];
      if (wr_data)      data_q <= bus_wdata;
      else if (rd_fire) data_q <= mem_rdata;
      if (wr_ctrl) begin
        rie_q <= bus_wdata[B_RIE];
        if (!busy) mode_q <= req_mode;
      end
    end
  end

  eectl_arm #(.WIN(ARM_WIN)) u_arm (
    .clk(clk), .rst_n(rst_n), .load(arm_load), .armed(armed)
  );

  eectl_seq #(
    .AW(AW), .DW(DW), .ATOMIC_CYC(ATOMIC_CYC), .SPLIT_CYC(SPLIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go_req), .mode(req_mode),
    .addr(addr_q), .data(data_q), .busy(busy), .done(done),
    .op_mode(op_mode), .op_addr(op_addr), .op_data(op_data)
  );

  eectl_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(done), .wmode(op_mode), .waddr(op_addr),
    .wdata(op_data), .raddr(addr_q), .rdata(mem_rdata)
  );

  always_comb begin
    case (bus_sel)
      SEL_ADDR: bus_rdata = DW'(addr_q);
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = {2'b00, mode_q, rie_q, armed, busy, 1'b0};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = rie_q && gie && !busy;

  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy) |=> $stable(mode_q));

  // R9
  busy_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_RD] && busy) |=> $stable(data_q));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_CTRL) |-> (bus_rdata[7:6] == 2'b00));
endmodule

// File: tb/tb_eectl_top.sv
module tb_eectl_top;
  localparam int AT = 34;
  localparam int SP = 18;

  logic       clk = 1'b0;
  logic       rst_n, bus_wr, gie, irq;
  logic [1:0] bus_sel;
  logic [7:0] bus_wdata, bus_rdata;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  eectl_top #(.AW(7), .ATOMIC_CYC(AT), .SPLIT_CYC(SP), .ARM_WIN(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie), .irq(irq)
  );

  // rows: [25:24] kind, [22:16] address, [15:8] data, [7:0] expected byte
  localparam logic [31:0] VEC [7] = '{
    32'h00_05_3C_3C, 32'h02_05_F0_30, 32'h01_05_00_FF, 32'h02_05_A5_A5,
    32'h00_7F_81_81, 32'h02_7F_0F_01, 32'h01_00_11_FF
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input logic [1:0] m, input logic ie,
                                    input logic arm, input logic go, input logic rd);
    return {2'b00, m, ie, arm, go, rd};
  endfunction

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [7:0] d);
    bus_sel = s;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] r;
    n = 0;
    bus_read(2, r);
    while (r[1] && n < 1000) begin
      n++;
      @(negedge clk);
      bus_read(2, r);
    end
  endtask

  task automatic read_mem(input logic [6:0] a, input logic ie, output logic [7:0] d);
    bus_write(0, {1'b0, a});
    bus_write(2, cw(2'b00, ie, 0, 0, 1));
    bus_read(1, d);
  endtask

  task automatic do_reset(input int n);
    rst_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    string tag;
    bus_wr = 1'b0; bus_sel = 2'd0; bus_wdata = 8'h00; gie = 1'b1;
    do_reset(100);

    // R1 reset state
    bus_read(0, r); check("R1 addr", r, 8'h00);
    bus_read(1, r); check("R1 data", r, 8'h00);
    bus_read(2, r); check("R1 ctrl", r, 8'h00);
    check("R1 irq", irq, 0);

    // R2 reserved bits and unused select
    bus_write(2, 8'hC8);
    bus_read(2, r); check("R2 reserved", r, 8'h08);
    bus_write(3, 8'h55);
    bus_read(3, r); check("R2 sel3", r, 8'h00);

    // R10 interrupt gating
    check("R10 idle enabled", irq, 1);
    gie = 1'b0; #1; check("R10 gie low", irq, 0);
    gie = 1'b1;

    // table walk: R3 R4 R5
    foreach (VEC[i]) begin
      logic [1:0] m;
      m = VEC[i][25:24];
      tag = (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" : "R5";
      bus_write(0, {1'b0, VEC[i][22:16]});
      bus_write(1, VEC[i][15:8]);
      bus_write(2, cw(m, 1, 1, 0, 0));
      bus_write(2, cw(m, 1, 0, 1, 0));
      check({tag, " irq low while busy R10"}, irq, 0);
      wait_idle(n);
      check({tag, " busy cycles"}, n, (m == 2'b00) ? AT : SP);
      check("R10 irq after done", irq, 1);
      read_mem(VEC[i][22:16], 1, r);
      check({tag, " byte"}, r, VEC[i][7:0]);
    end

    // R9 read bit reads back 0
    bus_read(2, r); check("R9 read bit clear", r[0], 0);

    // R6 reserved kind
    bus_write(2, cw(2'b11, 1, 1, 0, 0));
    bus_write(2, cw(2'b11, 1, 0, 1, 0));
    bus_read(2, r); check("R6 no start", r[1], 0);

    // R7 no arm
    repeat (8) @(negedge clk);
    bus_write(2, cw(2'b00, 1, 0, 1, 0));
    bus_read(2, r); check("R7 unarmed", r[1], 0);
    // R7 last cycle of window accepted
    bus_write(0, 8'h10); bus_write(1, 8'h77);
    bus_write(2, cw(2'b00, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    bus_write(2, cw(2'b00, 1, 0, 1, 0));
    bus_read(2, r); check("R7 window edge accepted", r[1], 1);
    wait_idle(n);
    // R7 one cycle late rejected
    bus_write(2, cw(2'b00, 1, 1, 0, 0));
    repeat (3) @(negedge clk);
    bus_write(2, cw(2'b00, 1, 0, 1, 0));
    bus_read(2, r); check("R7 window expired", r[1], 0);
    read_mem(7'h10, 1, r); check("R7 byte", r, 8'h77);

    // R8 and R9 while busy
    bus_write(0, 8'h7F); bus_write(1, 8'h5A);
    bus_write(2, cw(2'b00, 1, 1, 0, 0));
    bus_write(2, cw(2'b00, 1, 0, 1, 0));
    bus_write(2, cw(2'b01, 1, 0, 0, 0));
    bus_read(2, r); check("R8 kind locked", r[5:4], 2'b00);
    bus_write(2, cw(2'b00, 1, 1, 0, 0));
    bus_write(2, cw(2'b00, 1, 0, 1, 0));
    bus_write(2, cw(2'b00, 1, 0, 0, 1));
    bus_read(1, r); check("R9 busy read ignored", r, 8'h5A);
    wait_idle(n); check("R8 not restarted", n, AT - 8);
    read_mem(7'h7F, 1, r); check("R3 byte after lock test", r, 8'h5A);

    // R11 reset while busy
    bus_write(0, 8'h09); bus_write(1, 8'h00);
    bus_write(2, cw(2'b01, 1, 1, 0, 0));
    bus_write(2, cw(2'b01, 1, 0, 1, 0));
    repeat (3) @(negedge clk);
    do_reset(3);
    bus_read(2, r); check("R11 kind kept busy", r, 8'h12);
    wait_idle(n);
    read_mem(7'h09, 0, r); check("R11 op completed", r, 8'hFF);
    bus_write(2, cw(2'b01, 0, 0, 0, 0));
    do_reset(3);
    bus_read(2, r); check("R11 idle reset clears kind", r, 8'h00);
    check("R1 irq after reset", irq, 0);

    summary();
    $finish;
  end
endmodule